// File: doc/BRIEF.md
# Iterative Integer Multiplier with Multiply-Add

A sequential multiplier for a 64-bit integer datapath. One operation is taken in through a valid/ready input port. The block forms the full double-width product of two operands over XLEN clock cycles. It can then add a third operand to that product and return either the upper or the lower half. The family of operations covers:

- the low product, with a signed-overflow flag, at doubleword and at word size;
- the signed and the unsigned high product, at doubleword and at word size;
- a low product against a sign-extended immediate;
- three multiply-add variants.

Each result comes with an overflow flag and three comparison bits that describe the result as a signed number.

Signed operations are reduced to an unsigned shift-add over operand magnitudes, and the sign is fixed afterwards. A new operation is accepted only while the unit is idle. A finished result is presented on a valid/ready output port. The result holds until the consumer takes it, and if the consumer is always ready, out_valid is a single-cycle done pulse.

Top module: `mul_unit`

## Requirements
- R1: in_ready is 1 only while no operation is in progress and no result is pending. An operation and its operands are captured on a rising edge where in_valid and in_ready are both 1. in_ready and out_valid are never both 1.
- R2: out_valid becomes 1 exactly XLEN rising edges after the edge that accepted the operation.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_result, out_ovf and out_cond stay unchanged. A result is handed over on an edge where out_valid and out_ready are both 1, and out_valid is 0 after that edge.
- R4: Op 0 (low doubleword) returns the low XLEN bits of the signed product of A and B. out_ovf is 1 unless product bits [2*XLEN-1:XLEN-1] are all 0 or all 1.
- R5: Op 1 (low word) multiplies the sign-extended low halves of A and B, and the upper halves of A and B are ignored. It returns the XLEN-bit product, and out_ovf is 1 unless product bits [XLEN-1:XLEN/2-1] are all 0 or all 1.
- R6: Op 2 (signed high word) and op 3 (unsigned high word) multiply the low halves of A and B. Op 2 treats them as signed and op 3 as unsigned. Both place the upper half of the XLEN-bit product into both halves of out_result.
- R7: Op 4 (signed high doubleword) and op 5 (unsigned high doubleword) return bits [2*XLEN-1:XLEN] of the product of A and B.
- R8: Op 6 (immediate) returns the low XLEN bits of A times the sign-extended IMMW-bit immediate, and B is ignored.
- R9: Multiply-add ops start from the 2*XLEN-bit product of A and B. Op 7 adds a sign-extended C to the signed product and returns the upper half. Op 9 does the same and returns the lower half. Op 8 adds a zero-extended C to the unsigned product and returns the upper half.
- R10: out_ovf is 0 for ops 2 through 9.
- R11: out_cond = {lt, gt, eq} compares out_result as a signed number against zero, and exactly one bit is 1.
- R12: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_op | input | 4 | Operation code 0..9 |
| in_a | input | XLEN | Operand A |
| in_b | input | XLEN | Operand B |
| in_c | input | XLEN | Addend C for multiply-add |
| in_imm | input | IMMW | Immediate multiplier for op 6 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Selected result |
| out_ovf | output | 1 | Signed overflow of low products |
| out_cond | output | 3 | {lt, gt, eq} of result against zero |

## Verification
The bench builds the unit with XLEN=64 and IMMW=16. At that size, full 128-bit products are reached, including the most negative operand times minus one and products whose upper 65 bits are just barely not a pure sign extension. Word operations are driven with junk in the upper operand halves to show that those bits are ignored. Multiply-add cases use negative addends whose carry ripples into the upper half. Some results are held back by the consumer for several cycles, so their stability and the single-cycle handover are observed.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MUL_LD   = 4'd0,
    OP_MUL_LW   = 4'd1,
    OP_MUL_HW   = 4'd2,
    OP_MUL_HWU  = 4'd3,
    OP_MUL_HD   = 4'd4,
    OP_MUL_HDU  = 4'd5,
    OP_MUL_LI   = 4'd6,
    OP_MADD_HD  = 4'd7,
    OP_MADD_HDU = 4'd8,
    OP_MADD_LD  = 4'd9
  } mul_op_e;

  function automatic logic op_signed(mul_op_e op);
    return !(op == OP_MUL_HWU || op == OP_MUL_HDU || op == OP_MADD_HDU);
  endfunction

  function automatic logic op_word(mul_op_e op);
    return op == OP_MUL_LW || op == OP_MUL_HW || op == OP_MUL_HWU;
  endfunction

  function automatic logic op_adds_c(mul_op_e op);
    return op == OP_MADD_HD || op == OP_MADD_HDU || op == OP_MADD_LD;
  endfunction
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  mul_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] ext_a, ext_b;
  logic            sgn, na, nb;

  always_comb begin
    sgn   = op_signed(op);
    ext_a = a;
    ext_b = (op == OP_MUL_LI) ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : b;
    if (op_word(op)) begin
      ext_a = {{HALF{sgn & a[HALF-1]}}, a[HALF-1:0]};
      ext_b = {{HALF{sgn & b[HALF-1]}}, b[HALF-1:0]};
    end
    na    = sgn & ext_a[XLEN-1];
    nb    = sgn & ext_b[XLEN-1];
    mag_a = na ? (~ext_a + 1'b1) : ext_a;
    mag_b = nb ? (~ext_b + 1'b1) : ext_b;
    neg   = na ^ nb;
  end
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   mcand,
  input  logic [XLEN-1:0]   mplier,
  output logic              busy,
  output logic              last,
  output logic [2*XLEN-1:0] prod
);
  localparam int CW = $clog2(XLEN);

  logic [XLEN-1:0] mc_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   step_sum;

  assign last     = busy && (cnt_q == CW'(XLEN - 1));
  assign step_sum = {1'b0, prod[2*XLEN-1:XLEN]} + (prod[0] ? {1'b0, mc_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      mc_q  <= '0;
      prod  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      mc_q  <= mcand;
      prod  <= {{XLEN{1'b0}}, mplier};
    end else if (busy) begin
      prod  <= {step_sum, prod[XLEN-1:1]};
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      busy  <= !last;
    end
  end

  // R2: the iteration stops right after its final step
  p_stop_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
  // R2: an idle core has its step counter parked at zero
  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cnt_q == '0);
  // R3: a finished product is not disturbed while idle
  p_prod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load |=> $stable(prod));
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix
  import mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mul_op_e           op,
  input  logic              neg,
  input  logic [2*XLEN-1:0] mag_prod,
  input  logic [XLEN-1:0]   c,
  output logic [XLEN-1:0]   result,
  output logic              ovf,
  output logic [2:0]        cond
);
  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] sprod, c_ext, sum;
  logic              lt, eq;

  always_comb begin
    sprod = neg ? (~mag_prod + 1'b1) : mag_prod;
    c_ext = {{XLEN{op_signed(op) & c[XLEN-1]}}, c};
    sum   = op_adds_c(op) ? sprod + c_ext : sprod;
    ovf   = 1'b0;
    unique case (op)
      OP_MUL_LW: begin
        result = sum[XLEN-1:0];
        ovf    = !((&sum[XLEN-1:HALF-1]) || !(|sum[XLEN-1:HALF-1]));
      end
      OP_MUL_HW, OP_MUL_HWU:
        result = {sum[XLEN-1:HALF], sum[XLEN-1:HALF]};
      OP_MUL_HD, OP_MUL_HDU, OP_MADD_HD, OP_MADD_HDU:
        result = sum[2*XLEN-1:XLEN];
      OP_MUL_LI, OP_MADD_LD:
        result = sum[XLEN-1:0];
      default: begin
        result = sum[XLEN-1:0];
        ovf    = !((&sum[2*XLEN-1:XLEN-1]) || !(|sum[2*XLEN-1:XLEN-1]));
      end
    endcase
    lt   = result[XLEN-1];
    eq   = (result == '0);
    cond = {lt, !lt && !eq, eq};
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [XLEN-1:0] in_c,
  input  logic [IMMW-1:0] in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_ovf,
  output logic [2:0]      out_cond
);
  localparam int LW = $clog2(XLEN) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e            state_q;
  mul_op_e           op_q;
  logic [XLEN-1:0]   c_q;
  logic              neg_q;
  logic [XLEN-1:0]   mag_a, mag_b;
  logic              neg_in;
  logic              accept, core_busy, core_last;
  logic [2*XLEN-1:0] core_prod;

  assign in_ready  = (state_q == S_IDLE);
  assign out_valid = (state_q == S_DONE);
  assign accept    = in_valid && in_ready;

  mul_operand_prep #(.XLEN(XLEN), .IMMW(IMMW)) u_prep (
    .op(mul_op_e'(in_op)), .a(in_a), .b(in_b), .imm(in_imm),
    .mag_a(mag_a), .mag_b(mag_b), .neg(neg_in)
  );

  mul_shift_add #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .mcand(mag_a), .mplier(mag_b),
    .busy(core_busy), .last(core_last), .prod(core_prod)
  );

  mul_result_fix #(.XLEN(XLEN)) u_fix (
    .op(op_q), .neg(neg_q), .mag_prod(core_prod), .c(c_q),
    .result(out_result), .ovf(out_ovf), .cond(out_cond)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_MUL_LD;
      c_q     <= '0;
      neg_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_RUN;
          op_q    <= mul_op_e'(in_op);
          c_q     <= in_c;
          neg_q   <= neg_in;
        end
        S_RUN:   if (core_last) state_q <= S_DONE;
        S_DONE:  if (out_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Latency monitor kept only for the checks below
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lat_q <= '0;
    else if (accept)            lat_q <= '0;
    else if (state_q == S_RUN)  lat_q <= lat_q + 1'b1;
  end

  // R1: input and output sides are never offered at once
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  // R1: an accepted operation keeps the core running
  p_accept_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> core_busy && !in_ready);
  // R2: result appears exactly XLEN edges after acceptance
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LW'(XLEN));
  // R3: a stalled result holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_ovf) && $stable(out_cond));
  // R3: handover drops valid
  p_handover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
  // R10: only the low products can overflow
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q != OP_MUL_LD && op_q != OP_MUL_LW |-> !out_ovf);
  // R6: high word results repeat in both halves
  p_hword_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == OP_MUL_HW || op_q == OP_MUL_HWU)
      |-> out_result[XLEN-1:XLEN/2] == out_result[XLEN/2-1:0]);
  // R11: exactly one comparison bit
  p_cond_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_cond) == 1);
endmodule

// File: tb/test_mul_unit.sv
module test_mul_unit;
  localparam int XLEN = 64;
  localparam int IMMW = 16;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    logic [2:0]  cond;
    longint      acc_edge;
    int          stall;
    string       tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [3:0]      in_op = '0;
  logic [63:0]     in_a = '0, in_b = '0, in_c = '0;
  logic [15:0]     in_imm = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [63:0]     out_result;
  logic            out_ovf;
  logic [2:0]      out_cond;

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  bit     drv_done = 1'b0;
  item_t  sb[$];

  mul_unit #(.XLEN(XLEN), .IMMW(IMMW)) i_mul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ovf(out_ovf), .out_cond(out_cond)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] sx(logic [63:0] v);
    return {{64{v[63]}}, v};
  endfunction
  function automatic logic [63:0] wsx(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic item_t model(int op, logic [63:0] a, logic [63:0] b,
                                  logic [63:0] c, logic [15:0] imm);
    item_t it;
    logic [127:0] p;
    it.ovf = 1'b0;
    case (op)
      0: begin p = sx(a) * sx(b); it.res = p[63:0];
               it.ovf = !(p[127:63] == '0 || p[127:63] == '1); it.tag = "R4"; end
      1: begin p = sx(wsx(a)) * sx(wsx(b)); it.res = p[63:0];
               it.ovf = !(p[63:31] == '0 || p[63:31] == '1); it.tag = "R5"; end
      2: begin p = sx(wsx(a)) * sx(wsx(b)); it.res = {p[63:32], p[63:32]}; it.tag = "R6"; end
      3: begin p = {96'b0, a[31:0]} * {96'b0, b[31:0]}; it.res = {p[63:32], p[63:32]}; it.tag = "R6"; end
      4: begin p = sx(a) * sx(b); it.res = p[127:64]; it.tag = "R7"; end
      5: begin p = {64'b0, a} * {64'b0, b}; it.res = p[127:64]; it.tag = "R7"; end
      6: begin p = sx(a) * sx({{48{imm[15]}}, imm}); it.res = p[63:0]; it.tag = "R8"; end
      7: begin p = sx(a) * sx(b) + sx(c); it.res = p[127:64]; it.tag = "R9"; end
      8: begin p = {64'b0, a} * {64'b0, b} + {64'b0, c}; it.res = p[127:64]; it.tag = "R9"; end
      default: begin p = sx(a) * sx(b) + sx(c); it.res = p[63:0]; it.tag = "R9"; end
    endcase
    it.cond = {$signed(it.res) < 0, $signed(it.res) > 0, it.res == 0};
    return it;
  endfunction

  task automatic issue(int op, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                       logic [15:0] imm, int stall);
    item_t it;
    do @(negedge clk); while (!in_ready);
    it = model(op, a, b, c, imm);
    it.acc_edge = cyc + 1;
    it.stall = stall;
    sb.push_back(it);
    in_valid = 1'b1; in_op = 4'(op); in_a = a; in_b = b; in_c = c; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
    in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
  endtask

  // Monitor: pops the scoreboard as results are presented
  initial begin
    item_t       it;
    bit          seen = 1'b0;
    bit          expect_low = 1'b0;
    int          stall_left = 0;
    logic [63:0] first_res = '0;
    forever begin
      @(negedge clk);
      if (expect_low) begin
        check("R3 valid drops after handover", 64'(out_valid), 64'd0);
        expect_low = 1'b0;
      end
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R1 unexpected result", 64'd1, 64'd0);
        end else begin
          it = sb[0];
          if (!seen) begin
            seen = 1'b1;
            check("R2 latency", 64'(cyc - it.acc_edge), 64'(XLEN));
            check({it.tag, " result"}, out_result, it.res);
            check({it.tag, " R10 overflow"}, 64'(out_ovf), 64'(it.ovf));
            check({it.tag, " R11 cond"}, 64'(out_cond), 64'(it.cond));
            stall_left = it.stall;
            first_res = out_result;
          end else begin
            check("R3 stalled result stable", out_result, first_res);
          end
          if (stall_left > 0) begin
            out_ready = 1'b0;
            stall_left--;
          end else begin
            out_ready = 1'b1;
            void'(sb.pop_front());
            seen = 1'b0;
            expect_low = 1'b1;
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 in_ready after reset", 64'(in_ready), 64'd1);
    check("R12 out_valid after reset", 64'(out_valid), 64'd0);

    // R4 low doubleword
    issue(0, 64'd7, 64'd9, 0, 0, 0);
    issue(0, -64'sd5, 64'd1000, 0, 0, 2);
    issue(0, 64'h1_0000_0000, 64'h1_0000_0000, 0, 0, 0);
    issue(0, 64'h8000_0000_0000_0000, -64'sd1, 0, 0, 0);
    issue(0, -64'sd1, -64'sd1, 0, 0, 0);
    issue(0, 64'h4000_0000_0000_0000, 64'd2, 0, 0, 0);
    issue(0, 64'hC000_0000_0000_0000, 64'd2, 0, 0, 0);
    issue(0, 64'd0, 64'h1234, 0, 0, 0);
    // R5 low word with junk upper halves
    issue(1, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0002, 0, 0, 0);
    issue(1, 64'hFFFF_0000_FFFF_FFFE, 64'hAAAA_AAAA_0000_0003, 0, 0, 3);
    issue(1, 64'h0000_0001_8000_0000, 64'h0000_0001_0000_0001, 0, 0, 0);
    // R6 high word
    issue(2, 64'h1111_1111_FFFF_FFFF, 64'h2222_2222_FFFF_FFFF, 0, 0, 0);
    issue(3, 64'h1111_1111_FFFF_FFFF, 64'h2222_2222_FFFF_FFFF, 0, 0, 0);
    issue(2, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 0, 0);
    // R7 high doubleword
    issue(4, -64'sd1, -64'sd1, 0, 0, 0);
    issue(5, -64'sd1, -64'sd1, 0, 0, 0);
    issue(4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 0);
    // R8 immediate, B ignored
    issue(6, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'hFFFF, 0);
    issue(6, 64'h0123_4567_89AB_CDEF, 64'd0, 0, 16'h7FFF, 0);
    issue(6, 64'h8000_0000_0000_0000, 64'd5, 0, 16'h8000, 0);
    // R9 multiply-add
    issue(7, 64'd3, 64'd4, -64'sd13, 0, 0);
    issue(9, 64'd3, 64'd4, -64'sd13, 0, 0);
    issue(8, -64'sd1, 64'd1, -64'sd1, 0, 0);
    issue(8, 64'd2, 64'd3, -64'sd1, 0, 0);
    issue(7, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 1);
    issue(9, -64'sd9, 64'd9, 64'd81, 0, 0);
    // Mixed random traffic over every op
    for (int k = 0; k < 40; k++) begin
      issue(k % 10, {$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, 16'($urandom), k % 3);
    end
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    check("R12 idle at end", 64'(in_ready), 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule